// File: doc/BRIEF.md
# Receive Label Filter and Word Queue

This block sits between one serial avionics-data receiver and the host processor. The decoder ahead of it delivers complete 32-bit words as one-cycle pulses. The block decides whether each word is kept, using two optional tests. The first test compares the 8-bit label against a 16-entry label table. The second test compares the two source/destination bits against a programmed pair. Words that pass are queued in a 32-word FIFO.

The host reads each stored word as two 16-bit halves. It can also enter a label-access mode. In that mode, successive write strobes fill the label table and successive read strobes return its entries, while reception is paused. The data-ready, half-full and full flags let the host service the queue in blocks. When the queue is full, the next accepted word replaces the newest stored entry.

Bit numbering: `word_in[0]` carries serial bit 1, so the label is `word_in[7:0]` and serial bits 9 and 10 are `word_in[8]` and `word_in[9]`.

Top module: `arx_rx_filter`

## Requirements
- R1: With `lbl_chk_en`=1 and `code_chk_en`=0, a word on `word_valid` is queued only if `word_in[7:0]` equals one of the 16 table entries, with the value 0x00 treated like any other label. A word that is not queued changes neither the flags nor the queue contents.
- R2: With `code_chk_en`=1 and `lbl_chk_en`=0, a word is queued only if `word_in[8]` equals `code_ref[0]` and `word_in[9]` equals `code_ref[1]`.
- R3: With both checks on, a word must pass both to be queued. With both checks off, every word is queued.
- R4: While `lbl_mode`=1, each `host_wr` strobe writes `lbl_wdata` into the table entry at an index that starts at 0 when the mode is entered and steps 0 to 15. The index wraps to 0 after entry 15.
- R5: While `lbl_mode`=1, words on `word_valid` are never queued, and the FIFO level does not change.
- R6: While `lbl_mode`=1, `rd_data[7:0]` shows the table entry at the current index and `rd_data[15:8]` is zero. Each `host_rd` strobe steps the index, so reads return entries 0 to 15 in order.
- R7: `data_ready` is 1 when at least one word is queued, `half_full` is 1 at 16 or more words, and `full` is 1 at 32 words. The flags update in the cycle after the clock edge that changes the level.
- R8: When the queue holds 32 words and no word is removed in the same cycle, an accepted word replaces the 32nd (newest) entry and the level stays 32.
- R9: Outside label mode, `rd_data` shows `word_in[15:0]` of the oldest word when `half_sel`=0 and `word_in[31:16]` when `half_sel`=1. Only a `host_rd` strobe with `half_sel`=1 removes the word. A strobe with `half_sel`=0, or any strobe while the queue is empty, removes nothing.
- R10: A synchronous reset (`rst_n`=0) empties the queue and clears all flags, and leaves the label table contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | One-cycle pulse: `word_in` holds a complete received word |
| word_in | input | 32 | Received word, bit 0 = serial bit 1 |
| lbl_chk_en | input | 1 | Enable the label-table test |
| code_chk_en | input | 1 | Enable the source/destination bit test |
| code_ref | input | 2 | Required values of serial bits 10 and 9 (bit 1, bit 0) |
| lbl_mode | input | 1 | Label-access mode; pauses reception |
| host_wr | input | 1 | Host write strobe (label writes in label mode) |
| lbl_wdata | input | 8 | Label value written by `host_wr` |
| host_rd | input | 1 | Host read strobe |
| half_sel | input | 1 | Selects the lower (0) or upper (1) half of the oldest word |
| rd_data | output | 16 | Read data toward the host |
| data_ready | output | 1 | Queue not empty |
| half_full | output | 1 | Queue holds at least 16 words |
| full | output | 1 | Queue holds 32 words |

## Verification
The assertions assume three things about the inputs. Strobes are single-cycle, level-sensitive pulses sampled at the rising edge. The decoder does not present words while the host is changing mode. The host reads the lower half before the upper half.

The bench drives every input on the falling edge and holds each strobe for exactly one rising edge. It changes `lbl_mode` and the check enables only while no word or strobe is pending. Random traffic mixes labels from the programmed table with arbitrary bytes, so both accepted and rejected words are exercised under every filter setting.

// File: rtl/arx_pkg.sv
// Shared types and sizes for the receive label filter.
// Assumes word bit 0 carries serial bit 1.
package arx_pkg;
    localparam int WORD_W  = 32;
    localparam int LABEL_W = 8;
    localparam int HALF_W  = WORD_W / 2;

    typedef logic [WORD_W-1:0]  rx_word_t;
    typedef logic [LABEL_W-1:0] label_t;

    // Extract the 8-bit label field of a received word.
    function automatic label_t label_of(input rx_word_t w);
        return w[LABEL_W-1:0];
    endfunction

    // Extract serial bits 10 and 9 as a 2-bit code.
    function automatic logic [1:0] code_of(input rx_word_t w);
        return w[LABEL_W+1:LABEL_W];
    endfunction
endpackage

// File: rtl/arx_label_table.sv
// Label table: ENTRIES labels written and read in sequence by the host,
// compared in parallel against a probe label.
// Assumes: rd/wr are single-cycle and only asserted while mode=1.
// The table contents are not reset.
module arx_label_table
    import arx_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mode,
    input  logic   wr,
    input  logic   rd,
    input  label_t wdata,
    input  label_t probe,
    output logic   hit,
    output label_t rdata
);
    localparam int IW = $clog2(ENTRIES);

    label_t          tbl [ENTRIES];
    logic [IW-1:0]   idx_q;
    logic            mode_q;
    logic [IW-1:0]   idx;
    logic [ENTRIES-1:0] hit_vec;

    // Index restarts at zero in the first cycle of label mode.
    assign idx = (mode && !mode_q) ? '0 : idx_q;

    // Track mode and step the sequential index on each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            mode_q <= mode;
            if (mode && (wr || rd)) idx_q <= idx + 1'b1;
            else                    idx_q <= idx;
        end
    end

    // Store host label writes; no reset so contents survive reset.
    always_ff @(posedge clk) begin
        if (mode && wr) tbl[idx] <= wdata;
    end

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = (tbl[g] == probe);
    end

    assign hit   = |hit_vec;
    assign rdata = tbl[idx];
endmodule

// File: rtl/arx_word_fifo.sv
// Word FIFO that keeps the newest slot for overflow: a push into a full
// queue with no pop replaces the last written entry.
// Assumes DEPTH is a power of two.
module arx_word_fifo
    import arx_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  rx_word_t                   din,
    output rx_word_t                   dout,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);

    rx_word_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   cnt;
    logic            do_pop, do_push, do_over;
    logic [AW-1:0]   wr_idx;

    assign do_pop  = pop && (cnt != '0);
    assign do_push = push && ((cnt != LVL_FULL) || do_pop);
    assign do_over = push && !do_push;
    assign wr_idx  = do_over ? (wr_ptr - 1'b1) : wr_ptr;

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Storage write, including the overwrite of the newest entry.
    always_ff @(posedge clk) begin
        if (do_push || do_over) mem[wr_idx] <= din;
    end

    assign dout  = mem[rd_ptr];
    assign level = cnt;
endmodule

// File: rtl/arx_rx_filter.sv
// Receive label filter top: acceptance decision, label table access,
// word queue and host read path.
// Assumes single-cycle strobes and lower-half-first reads.
module arx_rx_filter
    import arx_pkg::*;
#(
    parameter int LBL_ENTRIES = 16,
    parameter int FIFO_DEPTH  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_valid,
    input  logic [31:0] word_in,
    input  logic        lbl_chk_en,
    input  logic        code_chk_en,
    input  logic [1:0]  code_ref,
    input  logic        lbl_mode,
    input  logic        host_wr,
    input  logic [7:0]  lbl_wdata,
    input  logic        host_rd,
    input  logic        half_sel,
    output logic [15:0] rd_data,
    output logic        data_ready,
    output logic        half_full,
    output logic        full
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam logic [CW-1:0] LVL_FULL = CW'(FIFO_DEPTH);
    localparam logic [CW-1:0] LVL_HALF = CW'(FIFO_DEPTH / 2);

    logic          lbl_hit;
    label_t        lbl_rdata;
    logic          lbl_ok, code_ok;
    logic          acc_push, acc_pop;
    rx_word_t      head;
    logic [CW-1:0] fifo_level;

    arx_label_table #(.ENTRIES(LBL_ENTRIES)) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (lbl_mode),
        .wr    (host_wr),
        .rd    (host_rd),
        .wdata (lbl_wdata),
        .probe (label_of(word_in)),
        .hit   (lbl_hit),
        .rdata (lbl_rdata)
    );

    // Acceptance: each enabled test must pass; reception paused in label mode.
    always_comb begin
        lbl_ok   = !lbl_chk_en || lbl_hit;
        code_ok  = !code_chk_en || (code_of(word_in) == code_ref);
        acc_push = word_valid && !lbl_mode && lbl_ok && code_ok;
        acc_pop  = host_rd && half_sel && !lbl_mode;
    end

    arx_word_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (acc_push),
        .pop   (acc_pop),
        .din   (word_in),
        .dout  (head),
        .level (fifo_level)
    );

    // Host read mux: label entry in label mode, else selected word half.
    always_comb begin
        if (lbl_mode)      rd_data = {8'h00, lbl_rdata};
        else if (half_sel) rd_data = head[WORD_W-1:HALF_W];
        else               rd_data = head[HALF_W-1:0];
    end

    assign data_ready = (fifo_level != '0);
    assign half_full  = (fifo_level >= LVL_HALF);
    assign full       = (fifo_level == LVL_FULL);
endmodule

// File: rtl/arx_rx_filter_chk.sv
// Checker for arx_rx_filter: flag ordering and queue level behaviour.
// Assumes it is bound into arx_rx_filter with its internal level and strobes.
module arx_rx_filter_chk #(
    parameter int CW = 6,
    parameter int FIFO_DEPTH = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lbl_mode,
    input logic          host_rd,
    input logic          half_sel,
    input logic          acc_push,
    input logic          acc_pop,
    input logic [CW-1:0] fifo_level,
    input logic          data_ready,
    input logic          half_full,
    input logic          full
);
    localparam logic [CW-1:0] LVL_FULL = CW'(FIFO_DEPTH);

    // R7
    flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full |-> half_full) and (half_full |-> data_ready));

    // R5
    lbl_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lbl_mode |=> (fifo_level == $past(fifo_level)));

    // R8
    overflow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == LVL_FULL && acc_push && !acc_pop) |=> full);

    // R9
    low_half_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !half_sel && !acc_push) |=> (fifo_level == $past(fifo_level)));

    // R7
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_FULL);

    // R10
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> !data_ready);
endmodule

bind arx_rx_filter arx_rx_filter_chk #(.CW(CW), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lbl_mode   (lbl_mode),
    .host_rd    (host_rd),
    .half_sel   (half_sel),
    .acc_push   (acc_push),
    .acc_pop    (acc_pop),
    .fifo_level (fifo_level),
    .data_ready (data_ready),
    .half_full  (half_full),
    .full       (full)
);

// File: tb/arx_rx_filter_test.sv
// Bench for arx_rx_filter: directed corners plus seeded random traffic
// checked against a queue model.
module arx_rx_filter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_in = '0;
    logic        lbl_chk_en = 1'b0;
    logic        code_chk_en = 1'b0;
    logic [1:0]  code_ref = 2'b00;
    logic        lbl_mode = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  lbl_wdata = '0;
    logic        host_rd = 1'b0;
    logic        half_sel = 1'b0;
    logic [15:0] rd_data;
    logic        data_ready, half_full, full;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    arx_rx_filter uut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
        .lbl_chk_en(lbl_chk_en), .code_chk_en(code_chk_en), .code_ref(code_ref),
        .lbl_mode(lbl_mode), .host_wr(host_wr), .lbl_wdata(lbl_wdata),
        .host_rd(host_rd), .half_sel(half_sel), .rd_data(rd_data),
        .data_ready(data_ready), .half_full(half_full), .full(full)
    );

    function automatic logic [7:0] tbl_label(input int i);
        return (i == 7) ? 8'h00 : 8'((i * 37 + 11) & 8'hff);
    endfunction

    function automatic bit in_table(input logic [7:0] l);
        for (int i = 0; i < 16; i++) if (tbl_label(i) == l) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit accepts(input logic [31:0] w);
        bit ok = 1'b1;
        if (lbl_chk_en && !in_table(w[7:0])) ok = 1'b0;
        if (code_chk_en && (w[9:8] != code_ref)) ok = 1'b0;
        return ok;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        int n = model.size();
        logic [2:0] exp = {n == 32, n >= 16, n != 0};
        logic [2:0] act = {full, half_full, data_ready};
        chk(act == exp, req, 32'(act), 32'(exp));
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        word_in = w; word_valid = 1'b1;
        if (!lbl_mode && accepts(w)) begin
            if (model.size() == 32) model[31] = w;
            else model.push_back(w);
        end
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic strobe_rd(input logic sel, output logic [15:0] seen);
        @(negedge clk);
        half_sel = sel;
        #1 seen = rd_data;
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic read_word(input string req);
        logic [15:0] lo, hi;
        logic [31:0] exp = model.pop_front();
        strobe_rd(1'b0, lo);
        strobe_rd(1'b1, hi);
        chk({hi, lo} == exp, req, {hi, lo}, exp);
    endtask

    task automatic drain(input string req);
        while (model.size() != 0) read_word(req);
        chk_flags(req);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model.delete();
    endtask

    task automatic random_run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w = $urandom;
            if ($urandom_range(1, 0) == 1) w[7:0] = tbl_label($urandom_range(15, 0));
            if ($urandom_range(9, 0) < 7 || model.size() == 0) begin
                send(w);
                chk_flags(req);
            end else begin
                read_word(req);
            end
        end
        drain(req);
    endtask

    initial begin
        logic [15:0] seen;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_flags("R7 reset flags");

        // R4: fill the label table in label mode.
        lbl_mode = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); lbl_wdata = tbl_label(i); host_wr = 1'b1;
            @(negedge clk); host_wr = 1'b0;
        end
        // R5: words offered in label mode are not queued.
        send(32'h0000_0000);
        send({24'h123456, tbl_label(3)});
        chk_flags("R5 reception paused");
        @(negedge clk); lbl_mode = 1'b0;
        @(negedge clk);
        chk_flags("R5 after label mode");

        // R6 / R4: re-enter, read back in order, then wrap.
        @(negedge clk); lbl_mode = 1'b1;
        for (int i = 0; i < 17; i++) begin
            strobe_rd(1'b0, seen);
            chk(seen == {8'h00, tbl_label(i % 16)}, (i == 16) ? "R4 index wrap" : "R6 label readback",
                32'(seen), 32'(tbl_label(i % 16)));
        end
        @(negedge clk); lbl_mode = 1'b0;

        // R1: label test only, including label 0x00.
        lbl_chk_en = 1'b1;
        send(32'hABCD_0000);
        chk_flags("R1 zero label accepted");
        send(32'hABCD_00FF);
        chk_flags("R1 unmatched label rejected");
        random_run(60, "R1 label filter");

        // R2: code test only.
        lbl_chk_en = 1'b0; code_chk_en = 1'b1; code_ref = 2'b10;
        send(32'h0000_0211);
        chk_flags("R2 code match");
        send(32'h0000_0111);
        chk_flags("R2 code mismatch");
        random_run(60, "R2 code filter");

        // R3: both tests, then neither.
        lbl_chk_en = 1'b1; code_ref = 2'b01;
        send({22'h0, 2'b01, tbl_label(5)});
        send({22'h0, 2'b11, tbl_label(5)});
        send({22'h0, 2'b01, 8'hFE});
        chk_flags("R3 both tests");
        random_run(60, "R3 both tests");
        lbl_chk_en = 1'b0; code_chk_en = 1'b0;
        random_run(60, "R3 no tests");

        // R9: lower-half strobe does not remove; empty read ignored.
        send(32'hCAFE_F00D);
        strobe_rd(1'b0, seen);
        strobe_rd(1'b0, seen);
        chk(seen == 16'hF00D, "R9 lower half repeat", 32'(seen), 32'hF00D);
        chk_flags("R9 no pop on lower half");
        read_word("R9 two-half read");
        strobe_rd(1'b1, seen);
        chk_flags("R9 read on empty");
        send(32'h1111_2222);
        read_word("R9 after empty read");

        // R7 / R8: fill to half, full, then overflow.
        for (int i = 0; i < 16; i++) send(32'h5000_0000 + 32'(i));
        chk_flags("R7 half full");
        for (int i = 16; i < 32; i++) send(32'h5000_0000 + 32'(i));
        chk_flags("R7 full");
        send(32'hDEAD_BEEF);
        send(32'hFACE_0001);
        chk_flags("R8 overflow keeps full");
        drain("R8 newest entry replaced");

        // R10: reset empties queue, keeps labels.
        for (int i = 0; i < 20; i++) send($urandom);
        do_reset();
        @(negedge clk);
        chk_flags("R10 reset clears");
        @(negedge clk); lbl_mode = 1'b1;
        for (int i = 0; i < 16; i++) begin
            strobe_rd(1'b0, seen);
            chk(seen[7:0] == tbl_label(i), "R10 labels kept", 32'(seen), 32'(tbl_label(i)));
        end
        @(negedge clk); lbl_mode = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule